// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA data). It runs entirely on a free-running crystal clock and treats SCL as data rather than as a clock. Both bus lines pass through a synchronizer and a glitch filter. Start and stop conditions are then decoded from the filtered lines. The block recognizes its own 7-bit address and gives a bus master read and write access to a 64-byte configuration register file.

The address is chosen by a strap pin. A write carries the address byte, then a register index, then any number of data bytes. A read returns bytes starting at the current index. In both cases the index advances after every byte.

The block never drives SDA high. Its only output is a pull-low enable, which the pad turns into an open-drain driver. Every change of that enable is delayed by a counted number of crystal periods after the falling SCL edge. This gives a guaranteed hold time and a known valid time for data on the bus. There is no streaming data interface: the register contents stay inside the block.

Top module: `twr_slave`

## Requirements
- R1: After reset, `sda_pull` is 0 (line released) and all 64 registers read as 0x00.
- R2: The 7-bit address is 0x4C when `addr_sel` is 0 and 0x4D when it is 1 (write address bytes 0x98 / 0x9A; bit 0 of the address byte is 1 for a read). On a match, the slave pulls SDA low during the ninth clock.
- R3: A non-matching address byte is not acknowledged. The slave then keeps SDA released and writes nothing until the next START.
- R4: In a write, the byte after the address is the register index (its low 6 bits are used). Each following data byte is stored at the index, which then increments. The index byte and every data byte are acknowledged.
- R5: The index wraps from 63 to 0, for writes and for reads.
- R6: A read returns the register at the current index, MSB first, and increments the index after each byte. When the master answers a byte with NACK (SDA high in the ninth clock), the slave releases SDA until the next START.
- R7: A pulse on SCL or SDA lasting 2 crystal periods or less is ignored. It causes no bit, START or STOP.
- R8: A START (SDA falls while SCL is high) begins a new address phase at any point, even in the middle of a byte. A STOP (SDA rises while SCL is high) releases SDA and idles the slave.
- R9: `sda_pull` becomes active only while SCL is low. It changes no earlier than 5 crystal periods after SCL falls, and within 20 crystal periods of that fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock (23 to 27 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Address strap: 0 selects 0x4C, 1 selects 0x4D |
| scl_in | input | 1 | Bus clock line, sampled asynchronously |
| sda_in | input | 1 | Bus data line as seen on the wire, sampled asynchronously |
| sda_pull | output | 1 | 1 = drive SDA low, 0 = release |

## Verification
A wrong bit counter or phase shows at the ports within one byte. The acknowledge appears in the wrong clock or does not appear at all, and a read returns data shifted by one or more bit positions. A wrong index register stays hidden until the next read. That read then returns a neighbour's value, or a stale zero, at the first byte past the fault. A glitch filter that is too permissive shows up as an extra bit, or as a false START or STOP, in the transaction that carries the glitch. A wrong output delay changes when `sda_pull` moves relative to the falling SCL edge.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // Protocol phase of the slave between START and STOP.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_WRITE,
    PH_READ
  } phase_e;

endpackage

// File: rtl/twr_filter.sv
// Two-flop synchronizer followed by a persistence filter: the filtered
// level follows the sampled level only after GLITCH+1 agreeing samples.
module twr_filter #(
  parameter int GLITCH    = 2,
  parameter bit IDLE_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic smp,
  output logic flt
);

  localparam int CW = $clog2(GLITCH + 1) + 1;

  logic          s1;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= IDLE_LVL;
      smp <= IDLE_LVL;
      flt <= IDLE_LVL;
      run <= '0;
    end else begin
      s1  <= raw;
      smp <= s1;
      if (smp == flt) begin
        run <= '0;
      end else if (run == CW'(GLITCH)) begin
        flt <= smp;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twr_regs.sv
// Configuration register file: one write port, one combinational read port.
module twr_regs #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/twr_proto.sv
// Bus protocol engine: condition detection, bit counting, address match,
// index handling and the delayed open-drain output.
module twr_proto
  import twr_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h4C,
  parameter int         AW        = 6,
  parameter int         OUT_DLY   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [7:0]    rdata,
  output logic          wr_en,
  output logic [AW-1:0] idx,
  output logic [7:0]    wr_byte,
  output logic          sda_pull
);

  localparam int DCW = $clog2(OUT_DLY + 1);

  phase_e         phase;
  logic [3:0]     bitn;     // rising edges seen in the current byte slot
  logic [7:0]     sh;       // received bits
  logic [7:0]     tx;       // byte being returned to the master
  logic           rw;
  logic           mnack;
  logic           pend;     // level to present once the delay expires
  logic           scl_q;
  logic           sda_q;
  logic [DCW-1:0] dly;

  logic rise_e, fall_e, start_e, stop_e, match;

  assign rise_e  = scl_f & ~scl_q;
  assign fall_e  = ~scl_f & scl_q;
  assign start_e = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_e  = scl_f & scl_q & ~sda_q & sda_f;
  assign match   = (sh[7:1] == (ADDR_BASE | {6'd0, addr_sel}));
  assign wr_en   = fall_e && (bitn == 4'd8) && (phase == PH_WRITE);
  assign wr_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitn     <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      mnack    <= 1'b1;
      pend     <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      dly      <= '0;
      idx      <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_e || stop_e) begin
        phase    <= start_e ? PH_ADDR : PH_IDLE;
        bitn     <= '0;
        dly      <= '0;
        pend     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        if (dly != '0) begin
          dly <= dly - 1'b1;
          if (dly == DCW'(1)) sda_pull <= pend;
        end
        if (rise_e && phase != PH_IDLE) begin
          if (bitn < 4'd8) sh <= {sh[6:0], sda_f};
          else             mnack <= sda_f;
          bitn <= bitn + 4'd1;
        end
        if (fall_e && phase != PH_IDLE) begin
          dly <= DCW'(OUT_DLY);
          if (bitn == 4'd8) begin
            // byte complete: decide the acknowledge
            case (phase)
              PH_ADDR: begin
                if (match) begin
                  pend <= 1'b1;
                  rw   <= sh[0];
                end else begin
                  pend  <= 1'b0;
                  phase <= PH_IDLE;
                end
              end
              PH_INDEX: begin
                idx  <= sh[AW-1:0];
                pend <= 1'b1;
              end
              PH_WRITE: begin
                idx  <= idx + 1'b1;
                pend <= 1'b1;
              end
              default: pend <= 1'b0;
            endcase
          end else if (bitn == 4'd9) begin
            // acknowledge slot over: set up the next byte
            bitn <= '0;
            if ((phase == PH_ADDR && rw) || (phase == PH_READ && !mnack)) begin
              phase <= PH_READ;
              tx    <= rdata;
              idx   <= idx + 1'b1;
              pend  <= ~rdata[7];
            end else begin
              pend <= 1'b0;
              if (phase == PH_ADDR)       phase <= PH_INDEX;
              else if (phase == PH_INDEX) phase <= PH_WRITE;
              else if (phase == PH_READ)  phase <= PH_IDLE;
            end
          end else begin
            pend <= (phase == PH_READ) && !tx[3'd7 - bitn[2:0]];
          end
        end
      end
    end
  end

endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
  parameter logic [6:0] ADDR_BASE  = 7'h4C,
  parameter int         REG_AW     = 6,
  parameter int         GLITCH_CYC = 2,
  parameter int         OUT_DLY    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_sel,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);

  localparam int NLINES = 2;   // index 0 = SCL, 1 = SDA

  logic [NLINES-1:0] raw_l, smp_l, flt_l;
  logic              scl_f, sda_f, wr_en;
  logic [REG_AW-1:0] idx;
  logic [7:0]        wr_byte, rdata;

  assign raw_l = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    twr_filter #(.GLITCH(GLITCH_CYC), .IDLE_LVL(1'b1)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_l[g]),
      .smp  (smp_l[g]),
      .flt  (flt_l[g])
    );
  end

  assign scl_f = flt_l[0];
  assign sda_f = flt_l[1];

  twr_proto #(.ADDR_BASE(ADDR_BASE), .AW(REG_AW), .OUT_DLY(OUT_DLY)) u_proto (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_sel(addr_sel),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .rdata   (rdata),
    .wr_en   (wr_en),
    .idx     (idx),
    .wr_byte (wr_byte),
    .sda_pull(sda_pull)
  );

  twr_regs #(.DW(8), .AW(REG_AW)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .addr (idx),
    .wdata(wr_byte),
    .rdata(rdata)
  );

endmodule

// File: rtl/twr_chk.sv
module twr_chk #(
  parameter int GLITCH  = 2,
  parameter int OUT_DLY = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] smp,
  input logic [1:0] flt,
  input logic       sda_pull
);

  localparam int HW = $clog2(GLITCH + 2) + 1;
  localparam int SW = $clog2(OUT_DLY + 2) + 1;

  logic [1:0]    smp_d;
  logic [HW-1:0] hold [2];
  logic [SW-1:0] since;
  logic          scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_d <= 2'b11;
      hold  <= '{default: '0};
      since <= '0;
      scl_d <= 1'b1;
    end else begin
      smp_d <= smp;
      scl_d <= flt[0];
      for (int i = 0; i < 2; i++) begin
        if (smp[i] != smp_d[i])      hold[i] <= '0;
        else if (hold[i] != '1)      hold[i] <= hold[i] + 1'b1;
      end
      if (scl_d && !flt[0])          since <= '0;
      else if (since != '1)          since <= since + 1'b1;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !sda_pull);

  for (genvar g = 0; g < 2; g++) begin : g_flt
    // R7
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt[g] != $past(flt[g])) |-> ($past(hold[g]) >= HW'(GLITCH - 1) && $past(smp[g]) == flt[g]));
  end

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt[0] && $past(flt[0]) && $rose(flt[1])) |=> !sda_pull);

  // R9
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !flt[0]);

  // R9
  pull_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (since >= SW'(OUT_DLY)));

endmodule

bind twr_slave twr_chk #(.GLITCH(GLITCH_CYC), .OUT_DLY(OUT_DLY)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp     (smp_l),
  .flt     (flt_l),
  .sda_pull(sda_pull)
);

// File: tb/test_twr_slave.sv
module test_twr_slave;

  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  twr_slave i_twr_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_sel(addr_sel),
    .scl_in  (m_scl),
    .sda_in  (sda_line),
    .sda_pull(sda_pull)
  );

  // output-delay monitor (R9)
  int  fc = 0;
  int  dmin = 1000;
  int  dmax = 0;
  bit  mon_en = 0;
  logic scl_p = 1'b1;
  logic pull_p = 1'b0;
  always @(posedge clk) begin
    if (scl_p && !m_scl) fc = 0;
    else if (fc < 1000)  fc = fc + 1;
    scl_p = m_scl;
    if (sda_pull !== pull_p && mon_en) begin
      if (fc < dmin) dmin = fc;
      if (fc > dmax) dmax = fc;
    end
    pull_p = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_sda = 1'b0; hw(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_sda = 1'b1; hw(HALF);
  endtask

  // kind: 0 none, 1 SCL low pulse, 2 SDA low pulse, during high phase of bit gbit
  task automatic send_g(input logic [7:0] b, input int gbit, input int kind, input int gw,
                        output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(HALF);
      m_scl = 1'b1; hw(HALF / 2);
      if (i == gbit && kind == 1) begin m_scl = 1'b0; hw(gw); m_scl = 1'b1; end
      if (i == gbit && kind == 2) begin m_sda = 1'b0; hw(gw); m_sda = 1'b1; end
      hw(HALF / 2);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hw(HALF);
    m_scl = 1'b1; hw(HALF / 2);
    ack = !sda_line;
    hw(HALF / 2);
    m_scl = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    send_g(b, 0, 0, 0, ack);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(HALF);
      m_scl = 1'b1; hw(HALF / 2);
      b = {b[6:0], sda_line};
      hw(HALF / 2);
      m_scl = 1'b0;
    end
    m_sda = !mack; hw(HALF);
    m_scl = 1'b1; hw(HALF);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic wr1(input logic [6:0] a, input logic [5:0] ix, input logic [7:0] d,
                     output bit a0, output bit a1, output bit a2);
    bus_start;
    send({a, 1'b0}, a0);
    send({2'b00, ix}, a1);
    send(d, a2);
    bus_stop;
  endtask

  task automatic rd1(input logic [6:0] a, input logic [5:0] ix, output logic [7:0] d);
    bit k;
    bus_start;
    send({a, 1'b0}, k);
    send({2'b00, ix}, k);
    bus_start;
    send({a, 1'b1}, k);
    recv(1'b0, d);
    bus_stop;
  endtask

  // {index, data} pairs written and read back
  localparam logic [13:0] VEC [6] = '{
    {6'd1,  8'hA5}, {6'd2,  8'h5A}, {6'd7,  8'hFF},
    {6'd33, 8'h01}, {6'd40, 8'h80}, {6'd63, 8'h3C}
  };

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run;
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] d, d1, d2;

    hw(5);
    chk_eq("R1 pull during reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    hw(5);
    chk_eq("R1 pull after reset", int'(sda_pull), 0);
    rd1(7'h4C, 6'd5, d);
    chk_eq("R1 register reset value", int'(d), 8'h00);

    // table walk: write then read back (R2, R4)
    for (int v = 0; v < 6; v++) begin
      wr1(7'h4C, VEC[v][13:8], VEC[v][7:0], a0, a1, a2);
      chk_eq("R2 address ack", int'(a0), 1);
      chk_eq("R4 index and data ack", int'({a1, a2}), 3);
      rd1(7'h4C, VEC[v][13:8], d);
      chk_eq("R4 stored value", int'(d), int'(VEC[v][7:0]));
    end

    // R2 / R3: strap selects 0x4D
    addr_sel = 1'b1;
    wr1(7'h4C, 6'd3, 8'h11, a0, a1, a2);
    chk_eq("R3 wrong address not acked", int'({a0, a1, a2}), 0);
    wr1(7'h4D, 6'd3, 8'h77, a0, a1, a2);
    chk_eq("R2 strap-high address acked", int'({a0, a1, a2}), 7);
    addr_sel = 1'b0;
    wr1(7'h4D, 6'd3, 8'h22, a0, a1, a2);
    chk_eq("R3 nack on mismatch", int'({a0, a1, a2}), 0);
    rd1(7'h4C, 6'd3, d);
    chk_eq("R3 write ignored", int'(d), 8'h77);

    // R4 / R5 / R6: burst across the wrap point
    bus_start;
    send(8'h98, a0); send(8'd62, a1);
    send(8'h10, a2); send(8'h20, a3); send(8'h30, a0);
    bus_stop;
    chk_eq("R4 burst acks", int'({a1, a2, a3, a0}), 15);
    mon_en = 1'b1;
    bus_start;
    send(8'h98, a0); send(8'd62, a0);
    bus_start;
    send(8'h99, a0);
    recv(1'b1, d); recv(1'b1, d1); recv(1'b0, d2);
    mon_en = 1'b0;
    chk_eq("R6 read byte at 62", int'(d), 8'h10);
    chk_eq("R5 read byte at 63", int'(d1), 8'h20);
    chk_eq("R5 read wraps to 0", int'(d2), 8'h30);
    // after NACK the slave stays released
    recv(1'b0, d);
    chk_eq("R6 released after nack", int'(d), 8'hFF);
    chk_eq("R6 pull off after nack", int'(sda_pull), 0);
    bus_stop;
    chk(dmin >= 5, "R9 minimum output delay", dmin, 5);
    chk(dmax <= 20, "R9 maximum output delay", dmax, 20);

    // R7: short pulses on SCL and SDA are ignored
    bus_start;
    send(8'h98, a0);
    send_g(8'd10, 3, 1, 2, a1);
    send_g(8'h5A, 3, 2, 2, a2);
    bus_stop;
    chk_eq("R7 glitched transaction acks", int'({a0, a1, a2}), 7);
    rd1(7'h4C, 6'd10, d);
    chk_eq("R7 glitch-free result", int'(d), 8'h5A);

    // R8: repeated START in the middle of a byte
    bus_start;
    send(8'h98, a0);
    for (int i = 0; i < 3; i++) begin
      m_sda = 1'b1; hw(HALF); m_scl = 1'b1; hw(HALF); m_scl = 1'b0;
    end
    bus_start;
    send(8'h98, a0); send(8'd20, a1); send(8'h3C, a2);
    bus_stop;
    chk_eq("R8 restart acks", int'({a0, a1, a2}), 7);
    chk_eq("R8 pull released after stop", int'(sda_pull), 0);
    rd1(7'h4C, 6'd20, d);
    chk_eq("R8 data after restart", int'(d), 8'h3C);

    done = 1;
    finish_run;
  end

endmodule